// File: doc/BRIEF.md
# Three-Channel Memory-Mapped Watchdog Timer

This block is a watchdog peripheral with three independent timer channels. All three share one reference clock and one 32-bit register bus. Each channel has an up-counter that advances on every clock. Software can overwrite the counter at any time, and writing zero to it is how software keeps the channel alive. Each channel also has a "bite" compare value and a control register. When a channel's reset enable is set and its counter has reached or passed the bite value, the channel requests a reset. Channel 0 requests a recovery-mode reset. Channels 1 and 2 share the normal machine-reset output.

Channel 0 also has a "bark" compare value for early warning. When its interrupt enable is set and its counter reaches the bark value, a sticky status bit is set and the interrupt line goes high. Software clears the status by writing 1 to that bit.

Because both triggers use a greater-or-equal compare, software can restart the machine at once. It writes a bite value of zero and sets reset enable.

Top module: `wdog_bank`

## Requirements
- R1: Each channel's counter increases by one on every clock and wraps from 0xFFFFFFFF to 0.
- R2: A bus write to a channel's counter loads the written value in place of that cycle's increment; the next cycle counts on from it.
- R3: Register map (byte address, 32-bit words): channel bases are 0x00, 0x10 and 0x20; counter +0x0, bite +0x4, bark +0x8 (channel 0 only), control +0xC. Control bits: bit 0 interrupt enable, bit 1 interrupt status, bit 2 reset enable. Reads return the stored values.
- R4: Reset outputs are registered. One clock after a channel's reset enable is 1 and its counter is >= its bite value, the output goes high. Channel 0 drives `recoveryRst`; channels 1 and 2 drive `machineRst`.
- R5: With a bite value of 0, setting reset enable raises the reset output one clock after the control write.
- R6: Clearing reset enable, or writing the counter below the bite value, drops the reset output one clock after the write.
- R7: One clock after channel 0's interrupt enable is 1 and its counter is >= its bark value, the status bit sets. `warnIrq` follows the status bit.
- R8: The status bit is sticky. Writing 1 to control bit 1 clears it, and writing 0 there leaves it unchanged. If a set condition and a clear happen in the same cycle, the set wins.
- R9: The following offsets read as zero, and writes to them are ignored: the bark offset of channels 1 and 2, addresses at 0x30 and above, and addresses whose two low bits are not zero.
- R10: After reset, every register is zero and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; counters advance on every rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | 6 | Byte address of the register read or written |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| recoveryRst | output | 1 | Recovery-mode reset request from channel 0 |
| machineRst | output | 1 | Normal reset request from channel 1 or 2 |
| warnIrq | output | 1 | Early-warning interrupt from channel 0 |

## Verification
The compare paths are driven with counters started just below the thresholds. This shows the exact cycle the output rises and separates greater-or-equal from strict greater-than. It also catches any off-by-one in the output register.

The counter path is tried with a mid-range load and with an all-ones load. The first tells a load that wins over the increment from one that adds to it. The second exposes a missing wrap.

The bite value of zero, the keepalive write and clearing the enable each exercise one way to raise or drop a reset. Writing 0 then 1 to the status bit separates a sticky interrupt from a level-following one. Writes to holes and misaligned addresses, followed by reads of the neighbouring real registers, show whether the decode aliases.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CH_N    = 3;
  localparam int CH_W    = $clog2(CH_N);
  localparam int ADDR_W  = CH_W + 4;
  localparam int BARK_CH = 0;

  // control bit positions
  localparam int CTL_IRQ_EN = 0;
  localparam int CTL_IRQ_ST = 1;
  localparam int CTL_RST_EN = 2;
  localparam int CTL_W      = 3;

  typedef enum logic [1:0] {
    FLD_CNT  = 2'd0,
    FLD_BITE = 2'd1,
    FLD_BARK = 2'd2,
    FLD_CTRL = 2'd3
  } fld_e;

  typedef struct packed {
    logic [CH_N-1:0] cntWr;
    logic [CH_N-1:0] biteWr;
    logic [CH_N-1:0] barkWr;
    logic [CH_N-1:0] ctrlWr;
    logic            rdValid;
    logic [CH_W-1:0] rdCh;
    fld_e            rdFld;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
  import wdog_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output wdStrobe_t         strobe
);
  logic [CH_W-1:0] chIdx;
  fld_e            fld;
  logic            aligned;
  logic            chOk;
  logic            fldOk;
  logic            hit;

  always_comb begin
    chIdx   = busAddr[ADDR_W-1:4];
    fld     = fld_e'(busAddr[3:2]);
    aligned = (busAddr[1:0] == 2'b00);
    chOk    = ({1'b0, chIdx} < (CH_W+1)'(CH_N));
    fldOk   = (fld != FLD_BARK) || (chIdx == CH_W'(BARK_CH));
    hit     = aligned && chOk && fldOk;

    strobe = '0;
    strobe.rdValid = hit;
    strobe.rdCh    = chIdx;
    strobe.rdFld   = fld;
    for (int i = 0; i < CH_N; i++) begin
      if (busWrEn && hit && chIdx == CH_W'(i)) begin
        strobe.cntWr[i]  = (fld == FLD_CNT);
        strobe.biteWr[i] = (fld == FLD_BITE);
        strobe.barkWr[i] = (fld == FLD_BARK);
        strobe.ctrlWr[i] = (fld == FLD_CTRL);
      end
    end
  end
endmodule

// File: rtl/wdog_channel.sv
module wdog_channel
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_BARK = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWr,
  input  logic             biteWr,
  input  logic             barkWr,
  input  logic             ctrlWr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] biteQ,
  output logic [CNT_W-1:0] barkQ,
  output logic [CTL_W-1:0] ctrlQ,
  output logic             rstHitQ,
  output logic             irqQ
);
  logic rstEnQ;
  logic irqEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      biteQ   <= '0;
      rstEnQ  <= 1'b0;
      rstHitQ <= 1'b0;
    end else begin
      cntQ    <= cntWr ? wrData : cntQ + CNT_W'(1);
      if (biteWr) biteQ <= wrData;
      if (ctrlWr) rstEnQ <= wrData[CTL_RST_EN];
      rstHitQ <= rstEnQ && (cntQ >= biteQ);
    end
  end

  generate
    if (HAS_BARK) begin : g_bark
      logic [CNT_W-1:0] barkR;
      logic             stR;
      logic             enR;
      logic             stClr;
      logic             stSet;
      assign stClr = ctrlWr && wrData[CTL_IRQ_ST];
      assign stSet = enR && (cntQ >= barkR);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          barkR <= '0;
          stR   <= 1'b0;
          enR   <= 1'b0;
        end else begin
          if (barkWr) barkR <= wrData;
          if (ctrlWr) enR <= wrData[CTL_IRQ_EN];
          stR <= (stR && !stClr) || stSet;
        end
      end
      assign barkQ  = barkR;
      assign irqQ   = stR;
      assign irqEnQ = enR;
    end else begin : g_nobark
      logic unusedBarkWr;
      assign unusedBarkWr = barkWr;
      assign barkQ  = '0;
      assign irqQ   = 1'b0;
      assign irqEnQ = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrlQ             = '0;
    ctrlQ[CTL_IRQ_EN] = irqEnQ;
    ctrlQ[CTL_IRQ_ST] = irqQ;
    ctrlQ[CTL_RST_EN] = rstEnQ;
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wdStrobe_t             strobe,
  input  logic [CNT_W-1:0]      wrData,
  output logic [CNT_W-1:0]      rdData,
  output logic [CH_N-1:0]       rstHit,
  output logic                  irqLine,
  output logic [CH_N*CNT_W-1:0] cntFlat,
  output logic [CH_N*CNT_W-1:0] biteFlat,
  output logic [CH_N-1:0]       rstEnVec
);
  logic [CNT_W-1:0] cntQ  [CH_N];
  logic [CNT_W-1:0] biteQ [CH_N];
  logic [CNT_W-1:0] barkQ [CH_N];
  logic [CTL_W-1:0] ctrlQ [CH_N];
  logic [CH_N-1:0]  irqVec;

  generate
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
      wdog_channel #(
        .CNT_W   (CNT_W),
        .HAS_BARK(ch == BARK_CH)
      ) uChan (
        .clk    (clk),
        .rstN   (rstN),
        .cntWr  (strobe.cntWr[ch]),
        .biteWr (strobe.biteWr[ch]),
        .barkWr (strobe.barkWr[ch]),
        .ctrlWr (strobe.ctrlWr[ch]),
        .wrData (wrData),
        .cntQ   (cntQ[ch]),
        .biteQ  (biteQ[ch]),
        .barkQ  (barkQ[ch]),
        .ctrlQ  (ctrlQ[ch]),
        .rstHitQ(rstHit[ch]),
        .irqQ   (irqVec[ch])
      );
      assign cntFlat[ch*CNT_W +: CNT_W]  = cntQ[ch];
      assign biteFlat[ch*CNT_W +: CNT_W] = biteQ[ch];
      assign rstEnVec[ch]                = ctrlQ[ch][CTL_RST_EN];
    end
  endgenerate

  assign irqLine = |irqVec;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < CH_N; i++) begin
      if (strobe.rdValid && strobe.rdCh == CH_W'(i)) begin
        case (strobe.rdFld)
          FLD_CNT:  rdData = cntQ[i];
          FLD_BITE: rdData = biteQ[i];
          FLD_BARK: rdData = barkQ[i];
          default:  rdData = {{(CNT_W-CTL_W){1'b0}}, ctrlQ[i]};
        endcase
      end
    end
  end
endmodule

// File: rtl/wdog_bank.sv
module wdog_bank
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic              recoveryRst,
  output logic              machineRst,
  output logic              warnIrq
);
  wdStrobe_t             strobe;
  logic [CH_N-1:0]       rstHit;
  logic [CH_N*CNT_W-1:0] chCnt;
  logic [CH_N*CNT_W-1:0] chBite;
  logic [CH_N-1:0]       chRstEn;

  wdog_decode uDecode (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  wdog_datapath #(.CNT_W(CNT_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .rstHit  (rstHit),
    .irqLine (warnIrq),
    .cntFlat (chCnt),
    .biteFlat(chBite),
    .rstEnVec(chRstEn)
  );

  assign recoveryRst = rstHit[0];
  assign machineRst  = |rstHit[CH_N-1:1];
endmodule

// File: rtl/wdog_bank_chk.sv
module wdog_bank_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [CNT_W-1:0]      busWrData,
  input logic                  recoveryRst,
  input logic                  machineRst,
  input logic                  warnIrq,
  input logic [CH_N*CNT_W-1:0] cntFlat,
  input logic [CH_N*CNT_W-1:0] biteFlat,
  input logic [CH_N-1:0]       rstEnVec
);
  logic [CNT_W-1:0] cnt1;
  logic [CNT_W-1:0] bite1;
  logic             cnt1Wr;
  logic             stClrWr;
  assign cnt1    = cntFlat[CNT_W +: CNT_W];
  assign bite1   = biteFlat[CNT_W +: CNT_W];
  assign cnt1Wr  = busWrEn && (busAddr == ADDR_W'(16));
  assign stClrWr = busWrEn && (busAddr == ADDR_W'(12)) && busWrData[CTL_IRQ_ST];

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cnt1Wr |=> cnt1 == $past(cnt1) + CNT_W'(1));

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt1Wr |=> cnt1 == $past(busWrData));

  // R4
  bite_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstEnVec[1] && cnt1 >= bite1) |=> machineRst);

  // R6
  recovery_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rstEnVec[0] |=> !recoveryRst);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warnIrq && !stClrWr) |=> warnIrq);
endmodule

bind wdog_bank wdog_bank_chk #(.CNT_W(CNT_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .recoveryRst(recoveryRst),
  .machineRst (machineRst),
  .warnIrq    (warnIrq),
  .cntFlat    (chCnt),
  .biteFlat   (chBite),
  .rstEnVec   (chRstEn)
);

// File: tb/tb_wdog_bank.sv
`timescale 1ns/1ps
module tb_wdog_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        recoveryRst;
  logic        machineRst;
  logic        warnIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam int SEL_RD = 0, SEL_REC = 1, SEL_MACH = 2, SEL_IRQ = 3;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  wdog_bank dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .recoveryRst(recoveryRst), .machineRst(machineRst), .warnIrq(warnIrq)
  );

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    tick();
    busWrEn = 1'b0; busWrData = '0;
  endtask

  // driver side: queue one expected item, the monitor compares it this half-cycle
  task automatic expectOut(input int sel, input logic [5:0] a,
                           input logic [31:0] e, input string req);
    item_t it;
    busAddr = a;
    it.sel = sel; it.exp = e; it.req = req;
    sbQ.push_back(it);
    tick();
  endtask

  // monitor: pops items and compares against the design outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        case (it.sel)
          SEL_RD:   act = busRdData;
          SEL_REC:  act = {31'b0, recoveryRst};
          SEL_MACH: act = {31'b0, machineRst};
          default:  act = {31'b0, warnIrq};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R10 reset state
    expectOut(SEL_RD, 6'h04, 32'h0, "R10 ch0 bite after reset");
    expectOut(SEL_RD, 6'h0C, 32'h0, "R10 ch0 ctrl after reset");
    expectOut(SEL_RD, 6'h1C, 32'h0, "R10 ch1 ctrl after reset");
    expectOut(SEL_REC, 6'h00, 32'h0, "R10 recoveryRst after reset");
    expectOut(SEL_MACH, 6'h00, 32'h0, "R10 machineRst after reset");
    expectOut(SEL_IRQ, 6'h00, 32'h0, "R10 warnIrq after reset");

    // R1 / R2 counter load and count
    wr(6'h10, 32'd100);
    expectOut(SEL_RD, 6'h10, 32'd100, "R2 loaded value replaces increment");
    expectOut(SEL_RD, 6'h10, 32'd101, "R1 count step");
    wr(6'h10, 32'hFFFF_FFFF);
    expectOut(SEL_RD, 6'h10, 32'hFFFF_FFFF, "R2 all-ones load");
    expectOut(SEL_RD, 6'h10, 32'h0, "R1 wrap to zero");

    // R4 bite compare on channel 1
    wr(6'h14, 32'd50);
    wr(6'h10, 32'd40);
    wr(6'h1C, 32'h4);
    repeat (9) tick();
    expectOut(SEL_MACH, 6'h00, 32'h0, "R4 counter 49 below bite");
    expectOut(SEL_MACH, 6'h00, 32'h1, "R4 counter equals bite");
    expectOut(SEL_REC, 6'h00, 32'h0, "R4 channel 1 does not drive recovery");
    expectOut(SEL_RD, 6'h14, 32'd50, "R3 ch1 bite readback");

    // R6 keepalive
    wr(6'h10, 32'h0);
    expectOut(SEL_MACH, 6'h00, 32'h1, "R4 output still registered after keepalive");
    expectOut(SEL_MACH, 6'h00, 32'h0, "R6 keepalive drops reset");
    wr(6'h1C, 32'h0);

    // R5 immediate restart on channel 2
    wr(6'h2C, 32'h4);
    expectOut(SEL_MACH, 6'h00, 32'h0, "R5 not yet high at control write");
    expectOut(SEL_MACH, 6'h00, 32'h1, "R5 bite zero fires");
    wr(6'h2C, 32'h0);
    expectOut(SEL_MACH, 6'h00, 32'h1, "R6 still high in write cycle");
    expectOut(SEL_MACH, 6'h00, 32'h0, "R6 disable drops reset");

    // R4 channel 0 to recovery
    wr(6'h0C, 32'h4);
    expectOut(SEL_REC, 6'h00, 32'h0, "R4 recovery one clock later");
    expectOut(SEL_REC, 6'h00, 32'h1, "R4 recovery asserted");
    expectOut(SEL_MACH, 6'h00, 32'h0, "R4 channel 0 does not drive machineRst");
    wr(6'h0C, 32'h0);
    tick();
    expectOut(SEL_REC, 6'h00, 32'h0, "R6 recovery released");

    // R7 bark on channel 0
    wr(6'h08, 32'd30);
    wr(6'h00, 32'd20);
    wr(6'h0C, 32'h1);
    repeat (9) tick();
    expectOut(SEL_IRQ, 6'h00, 32'h0, "R7 counter 29 below bark");
    expectOut(SEL_IRQ, 6'h00, 32'h1, "R7 counter equals bark");
    expectOut(SEL_RD, 6'h0C, 32'h3, "R3 ctrl shows enable and status");
    expectOut(SEL_RD, 6'h08, 32'd30, "R3 ch0 bark readback");

    // R8 sticky status
    wr(6'h00, 32'h0);
    expectOut(SEL_IRQ, 6'h00, 32'h1, "R8 status sticky below bark");
    wr(6'h0C, 32'h1);
    expectOut(SEL_IRQ, 6'h00, 32'h1, "R8 write 0 to status no effect");
    wr(6'h0C, 32'h2);
    expectOut(SEL_IRQ, 6'h00, 32'h0, "R8 write 1 clears status");
    expectOut(SEL_RD, 6'h0C, 32'h0, "R8 ctrl after clear");

    // R9 holes and misaligned addresses
    wr(6'h18, 32'hDEAD_BEEF);
    expectOut(SEL_RD, 6'h18, 32'h0, "R9 ch1 bark hole reads zero");
    wr(6'h34, 32'd5);
    wr(6'h06, 32'd77);
    wr(6'h15, 32'd99);
    expectOut(SEL_RD, 6'h04, 32'h0, "R9 ch0 bite untouched by hole writes");
    expectOut(SEL_RD, 6'h14, 32'd50, "R9 ch1 bite untouched by misaligned write");
    expectOut(SEL_RD, 6'h34, 32'h0, "R9 out-of-range reads zero");
    expectOut(SEL_RD, 6'h15, 32'h0, "R9 misaligned reads zero");

    tick();
    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule